// File: doc/BRIEF.md
# Configurable Action Watchdog Timer

This block is a down-counting supervision timer driven by the system clock. Software first programs a timeout value and picks what should happen when the timeout runs out. It then enables the timer and must keep restarting it by writing to a service address before the count reaches zero. If the count does reach zero, the block raises one of three request lines: a system reset request, a non-maskable interrupt request, or a general interrupt request. A fourth setting raises no line at all and only records the event.

A sticky status flag shows that the watchdog expired. The flag sits in its own reset domain and is cleared only by power-on reset, so it survives the system reset that the watchdog itself can cause. Software can then find out why the system restarted. A small register interface gives access to control, timeout value, live count and the service address.

The controller is a three-state machine. IDLE: the timer is stopped and the count holds. RUN: the count decrements. EXPIRED: the count has reached zero and the chosen line is held. The transitions are:
- START: IDLE to RUN, on a control write with enable set; the count is loaded.
- TICK: RUN to RUN, decrement by one.
- KICK: RUN to RUN, a service write reloads the count.
- FIRE: RUN to EXPIRED, the count is zero and there is no service write.
- RECOVER: EXPIRED to RUN, a service write reloads the count.
- STOP: RUN or EXPIRED to IDLE, a control write with enable clear.

Top module: `wdt_top`

## Requirements
- R1: After system and power-on reset the timer is in IDLE. CTRL reads 0, LOAD reads all ones, COUNT reads 0 and all three request lines are low.
- R2: After START the COUNT register holds the LOAD value. It then drops by exactly one on each clock while in RUN.
- R3: With LOAD = L, the chosen request line rises exactly L+1 clocks after the enabling write. It stays high until STOP or RECOVER.
- R4: CTRL bits [2:1] select the action. 00 selects the system reset request, 01 the non-maskable interrupt request and 10 the general interrupt request. 11 asserts no line; the counter stays at zero. At most one request line is ever high.
- R5: A write to address 3 (service) while in RUN reloads COUNT from LOAD. A service write in the same clock in which COUNT is zero prevents the expiry.
- R6: A service write while in EXPIRED drops the request line, reloads COUNT from LOAD and resumes counting.
- R7: While enabled (CTRL bit 0 reads 1), writes to LOAD and to the action field are ignored. Their readback is unchanged.
- R8: A CTRL write with bit 0 clear stops the timer and drops any request line. COUNT then holds its value.
- R9: CTRL bit 3 (status) is set at expiry for every action. It is not cleared by the system reset. It is cleared by power-on reset or by writing 1 to bit 3. If an expiry and a clear fall in the same clock, the set wins.
- R10: The address map is 0 CTRL, 1 LOAD, 2 COUNT and 3 service. COUNT is read-only: writes to it are ignored. The service address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; the only reset of the status flag |
| rst_n | input | 1 | System reset, active low; includes the reset the watchdog requests |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| sys_rst_req | output | 1 | System reset request on expiry |
| nmi_req | output | 1 | Non-maskable interrupt request on expiry |
| irq_req | output | 1 | General interrupt request on expiry |

## Verification
Two functions can fall in the same clock. The first pair is a service write and the count reaching zero. The bench counts the timer down to zero and issues the service write on exactly that edge; it then checks that no line rose and that COUNT was reloaded. The second pair is the status flag being set by an expiry and cleared by a write-one-to-clear in the same edge. The bench times a control write to land on the FIRE edge and then checks that the flag reads 1.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } wdt_state_e;

    typedef enum logic [1:0] {
        ACT_RESET = 2'b00,
        ACT_NMI   = 2'b01,
        ACT_IRQ   = 2'b10,
        ACT_NONE  = 2'b11
    } wdt_action_e;

    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_LOAD  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_KICK  = 2'd3;

    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_ACT_LSB = 1;
    localparam int unsigned CTRL_STS_BIT = 3;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enabled,
    input  logic             wr_ctrl,
    input  logic             wr_load,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] load_q,
    output wdt_action_e      action_q
);

    // Timeout value: locked while the timer runs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '1;
        end else if (wr_load && !enabled) begin
            load_q <= wdata;
        end
    end

    // Expiry action: locked while the timer runs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            action_q <= ACT_RESET;
        end else if (wr_ctrl && !enabled) begin
            action_q <= wdt_action_e'(wdata[CTRL_ACT_LSB +: 2]);
        end
    end

    AST_LOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load && enabled) |=> $stable(load_q)); // R7
    AST_ACTION_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |=> $stable(action_q)); // R7

endmodule

// File: rtl/wdt_sticky.sv
module wdt_sticky (
    input  logic clk,
    input  logic por_n,
    input  logic set_i,
    input  logic clr_i,
    output logic sts_o
);

    // Power-on domain only: the system reset does not reach this flop.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sts_o <= 1'b0;
        end else if (set_i) begin
            sts_o <= 1'b1;
        end else if (clr_i) begin
            sts_o <= 1'b0;
        end
    end

    AST_STATUS_SET: assert property (@(posedge clk) disable iff (!por_n)
        set_i |=> sts_o); // R9
    AST_STATUS_KEPT: assert property (@(posedge clk) disable iff (!por_n)
        (sts_o && !clr_i) |=> sts_o); // R9

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (load_i) begin
            cnt_o <= load_val;
        end else if (dec_i && !zero_o) begin
            cnt_o <= cnt_o - 1'b1;
        end
    end

    assign zero_o = (cnt_o == '0);

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && !zero_o) |=> (cnt_o == $past(cnt_o) - 1'b1)); // R2
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == $past(load_val))); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_i && !load_i) |=> $stable(cnt_o)); // R8

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_wr,
    input  logic        en_val,
    input  logic        kick,
    input  logic        cnt_zero,
    input  wdt_action_e action,
    output wdt_state_e  state,
    output logic        load_cnt,
    output logic        dec,
    output logic        fire,
    output logic        sys_rst_req,
    output logic        nmi_req,
    output logic        irq_req
);

    wdt_state_e nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt      = state;
        load_cnt = 1'b0;
        dec      = 1'b0;
        fire     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (en_wr && en_val) begin          // START
                    nxt      = ST_RUN;
                    load_cnt = 1'b1;
                end
            end
            ST_RUN: begin
                if (en_wr && !en_val) begin         // STOP
                    nxt = ST_IDLE;
                end else if (kick) begin            // KICK
                    load_cnt = 1'b1;
                end else if (cnt_zero) begin        // FIRE
                    nxt  = ST_EXPIRED;
                    fire = 1'b1;
                end else begin                      // TICK
                    dec = 1'b1;
                end
            end
            ST_EXPIRED: begin
                if (en_wr && !en_val) begin         // STOP
                    nxt = ST_IDLE;
                end else if (kick) begin            // RECOVER
                    nxt      = ST_RUN;
                    load_cnt = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sys_rst_req = 1'b0;
        nmi_req     = 1'b0;
        irq_req     = 1'b0;
        if (state == ST_EXPIRED) begin
            unique case (action)
                ACT_RESET: sys_rst_req = 1'b1;
                ACT_NMI:   nmi_req     = 1'b1;
                ACT_IRQ:   irq_req     = 1'b1;
                ACT_NONE:  ;
            endcase
        end
    end

    AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_rst_req, nmi_req, irq_req})); // R4
    AST_FIRE_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !cnt_zero) |=> (state != ST_EXPIRED)); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((sys_rst_req || nmi_req || irq_req) && !en_wr && !kick)
        |=> $stable({sys_rst_req, nmi_req, irq_req})); // R3

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             sys_rst_req,
    output logic             nmi_req,
    output logic             irq_req
);

    wdt_state_e       state;
    wdt_action_e      action_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;
    logic             load_cnt;
    logic             dec;
    logic             fire;
    logic             sts;
    logic             enabled;
    logic             wr_ctrl;
    logic             wr_load;
    logic             wr_kick;

    assign wr_ctrl = wr_en && (addr == ADR_CTRL);
    assign wr_load = wr_en && (addr == ADR_LOAD);
    assign wr_kick = wr_en && (addr == ADR_KICK);
    assign enabled = (state != ST_IDLE);

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .enabled  (enabled),
        .wr_ctrl  (wr_ctrl),
        .wr_load  (wr_load),
        .wdata    (wdata),
        .load_q   (load_q),
        .action_q (action_q)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_cnt),
        .load_val (load_q),
        .dec_i    (dec),
        .cnt_o    (cnt),
        .zero_o   (cnt_zero)
    );

    wdt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_wr       (wr_ctrl),
        .en_val      (wdata[CTRL_EN_BIT]),
        .kick        (wr_kick),
        .cnt_zero    (cnt_zero),
        .action      (action_q),
        .state       (state),
        .load_cnt    (load_cnt),
        .dec         (dec),
        .fire        (fire),
        .sys_rst_req (sys_rst_req),
        .nmi_req     (nmi_req),
        .irq_req     (irq_req)
    );

    wdt_sticky u_sts (
        .clk   (clk),
        .por_n (por_n),
        .set_i (fire),
        .clr_i (wr_ctrl && wdata[CTRL_STS_BIT]),
        .sts_o (sts)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: begin
                rdata[CTRL_EN_BIT]        = enabled;
                rdata[CTRL_ACT_LSB +: 2]  = action_q;
                rdata[CTRL_STS_BIT]       = sts;
            end
            ADR_LOAD:  rdata = load_q;
            ADR_COUNT: rdata = cnt;
            default:   rdata = '0;
        endcase
    end

    AST_NO_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> !(sys_rst_req || nmi_req || irq_req)); // R8

endmodule

// File: tb/test_wdt_top.sv
`timescale 1ns/1ps
module test_wdt_top;

    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic          sys_rst_req, nmi_req, irq_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wdt_top #(.CNT_W(CW)) i_wdt_top (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sys_rst_req(sys_rst_req),
        .nmi_req(nmi_req), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [CW-1:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [CW-1:0] reqs();
        return {29'd0, irq_req, nmi_req, sys_rst_req};
    endfunction

    // Starts the timer: load, then action, then enable.
    task automatic start(input logic [CW-1:0] l, input logic [1:0] act);
        wr(2'd1, l);
        wr(2'd0, {29'd0, act, 1'b0});
        wr(2'd0, {29'd0, act, 1'b1});
    endtask

    task automatic t_reset();
        logic [CW-1:0] v;
        rd(2'd0, v); check("R1 ctrl", v, 0);
        rd(2'd1, v); check("R1 load", v, '1);
        rd(2'd2, v); check("R1 count", v, 0);
        check("R1 reqs", reqs(), 0);
    endtask

    task automatic t_expire(input logic [1:0] act, input logic [2:0] exp_req);
        logic [CW-1:0] v;
        wr(2'd0, 32'h8);                    // clear status
        start(32'd8, act);
        tick(3);
        rd(2'd2, v); check("R2 count after 3", v, 32'd5);
        tick(5);
        rd(2'd2, v); check("R3 count at zero", v, 0);
        check("R3 no req before expiry", reqs(), 0);
        tick(1);
        check("R4 req for action", reqs(), {29'd0, exp_req});
        rd(2'd0, v); check("R9 status set", {31'd0, v[3]}, 1);
        rd(2'd2, v); check("R4 count stays zero", v, 0);
        tick(4);
        check("R3 req held", reqs(), {29'd0, exp_req});
        wr(2'd0, {29'd0, act, 1'b0});
        check("R8 req dropped", reqs(), 0);
        rd(2'd0, v); check("R8 disabled", {31'd0, v[0]}, 0);
    endtask

    task automatic t_kick_race();
        logic [CW-1:0] v;
        start(32'd5, 2'b01);
        tick(5);
        rd(2'd2, v); check("R5 at zero", v, 0);
        wr(2'd3, 0);                        // lands on the FIRE edge
        check("R5 no expiry", reqs(), 0);
        rd(2'd2, v); check("R5 reloaded", v, 32'd5);
        tick(2);
        wr(2'd3, 0);
        rd(2'd2, v); check("R5 mid kick", v, 32'd5);
        wr(2'd0, 32'h2);
    endtask

    task automatic t_recover();
        logic [CW-1:0] v;
        start(32'd3, 2'b10);
        tick(4);
        check("R6 irq up", reqs(), 32'd4);
        wr(2'd3, 0);
        check("R6 irq dropped", reqs(), 0);
        rd(2'd2, v); check("R6 reloaded", v, 32'd3);
        tick(1);
        rd(2'd2, v); check("R6 counting", v, 32'd2);
        wr(2'd0, 32'h4);
    endtask

    task automatic t_lock();
        logic [CW-1:0] v, w;
        start(32'd40, 2'b10);
        wr(2'd1, 32'd7);
        rd(2'd1, v); check("R7 load locked", v, 32'd40);
        wr(2'd0, 32'h3);                    // enable, action 01
        rd(2'd0, v); check("R7 action locked", {30'd0, v[2:1]}, 32'd2);
        wr(2'd2, 32'd99);
        rd(2'd2, v); check("R10 count read-only", v, 32'd37);
        wr(2'd0, 32'h4);
        rd(2'd2, v);
        tick(3);
        rd(2'd2, w); check("R8 count holds", w, v);
        rd(2'd3, v); check("R10 service reads 0", v, 0);
    endtask

    task automatic t_status();
        logic [CW-1:0] v;
        wr(2'd0, 32'h8);
        start(32'd2, 2'b00);
        tick(3);
        check("R4 reset req", reqs(), 1);
        rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
        check("R9 reset req gone", reqs(), 0);
        rd(2'd0, v); check("R9 status survives", v, 32'h8);
        wr(2'd0, 32'h8);
        rd(2'd0, v); check("R9 w1c clears", v, 0);
        start(32'd2, 2'b11);
        tick(2);
        wr(2'd0, 32'hF);                    // clear on the FIRE edge
        rd(2'd0, v); check("R9 set beats clear", {31'd0, v[3]}, 1);
        check("R4 none action", reqs(), 0);
        wr(2'd0, 32'h6);
        por_n = 1'b0; rst_n = 1'b0; tick(1); por_n = 1'b1; rst_n = 1'b1; tick(1);
        rd(2'd0, v); check("R1 R9 por clears", v, 0);
    endtask

    initial begin
        #1ms;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        por_n = 1'b1; rst_n = 1'b1;
        tick(1);
        t_reset();
        t_expire(2'b00, 3'b001);
        t_expire(2'b01, 3'b010);
        t_expire(2'b10, 3'b100);
        t_expire(2'b11, 3'b000);
        t_kick_race();
        t_recover();
        t_lock();
        t_status();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule